// File: doc/BRIEF.md
# Microprogram Address Sequencer with Loop Counter

This block produces the 12-bit address of the microinstruction to execute in each machine cycle. The sequencing control fields of the current microword pick where the next address comes from: the incremented address, a jump field, a jump qualified by an external test bit, a return register loaded by a subroutine call, a loop that runs while an iteration counter is non-zero, or an opcode map lookup that starts a new instruction routine. The same fields can ask for an instruction word to be fetched into a two-deep instruction pipeline, and can load the iteration counter.

At an instruction boundary, the block settles what runs next. A pending hold request goes first. A pending interrupt request goes next. Otherwise the opcode in the older pipeline slot is dispatched through the internal map. After a hold is left, exactly one instruction is dispatched before a still-pending interrupt is honoured. A stall input freezes every register, so sequencing can be suspended while another master owns the bus.

Instruction words arrive on a valid/ready stream. Ready is high only while the current microword requests a fetch and the block is not stalled or in reset. A transfer happens on a clock edge where valid and ready are both high. If a fetch is requested and valid is low, the sequencer waits: the address, the counter and the pipeline all hold until a word arrives. Valid may rise or fall at any time, and data is taken only on a transfer.

Top module: `useq_addr_gen`

## Requirements
- R1: While `rst` is high, at the next edge `uaddr` becomes 0, `cur_instr` becomes 0 and the counter becomes 0, so `cnt_done` is 1. The first edge after `rst` falls begins sequencing from address 0.
- R2: With `mw_op`=0 (next), the address becomes `uaddr`+1 modulo 4096.
- R3: With `mw_op`=1 (jump), the address becomes `mw_jump`.
- R4: With `mw_op`=2 (conditional jump), the address becomes `mw_jump` when `test_t` is 1, and `uaddr`+1 otherwise.
- R5: `mw_op`=3 (call) stores `uaddr`+1 in the return register and jumps to `mw_jump`. `mw_op`=4 (return) takes the address from the return register.
- R6: With `mw_op`=5 (loop), a non-zero counter is decremented and the address becomes `mw_jump`. A zero counter lets flow fall through to `uaddr`+1. `cnt_done` is 1 exactly when the counter is 0.
- R7: When `mw_cnt_ld` is 1, the counter loads `data_bus` if `mw_cnt_bus` is 1, and `mw_cnt_val` otherwise. A load takes priority over a loop decrement in the same cycle.
- R8: `instr_ready` = `mw_fetch` & !`stall` & !`rst`. On a transfer, the new word enters slot A and the old slot A moves to slot B. `cur_instr` shows slot B. A fetch with `instr_valid` low holds all state.
- R9: With `mw_op`=6 (end) and no hold or interrupt taken, the address becomes {`MAP_BASE`, m}, where m = {op[3:0], op[7:4]} XOR 8'hA5 and op = `cur_instr[15:8]`.
- R10: With `mw_op`=6 and `hold_n`=0, the address becomes `HOLD_VEC` (0x0F0) whatever `irq_n` is. With `hold_n`=1 and `irq_n`=0, it becomes `IRQ_VEC` (0x0E0), except as stated in R11.
- R11: `mw_op`=7 (hold wait) keeps the address while `hold_n`=0. When `hold_n`=1, it advances by one and arms a skip. The next end that is not taken by a hold dispatches the opcode despite `irq_n`=0, and clears the skip.
- R12: While `stall` is 1, the address, return register, counter, pipeline and skip flag all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze all state |
| mw_op | input | 3 | Next-address operation from the microword |
| mw_jump | input | 12 | Jump field from the microword |
| mw_fetch | input | 1 | Request an instruction word this cycle |
| mw_cnt_ld | input | 1 | Load the iteration counter |
| mw_cnt_bus | input | 1 | Counter load source: 1 = data bus, 0 = microword field |
| mw_cnt_val | input | 16 | Counter value from the microword |
| test_t | input | 1 | Condition bit for the conditional jump |
| hold_n | input | 1 | Hold request, active low |
| irq_n | input | 1 | Interrupt request, active low |
| data_bus | input | 16 | Data bus value for counter loads |
| instr_valid | input | 1 | Instruction stream valid |
| instr_ready | output | 1 | Instruction stream ready |
| instr_data | input | 16 | Instruction stream word |
| uaddr | output | 12 | Current microcode address |
| cnt_done | output | 1 | Iteration counter is zero |
| cur_instr | output | 16 | Older pipeline slot (instruction being dispatched) |

## Verification
The bench goes after the instruction boundary when hold and interrupt are low together. A design with the priority reversed lands on `IRQ_VEC`. It also exercises the single instruction that must follow a hold. A missing skip would enter the interrupt vector straight after the hold; a skip that never clears would hide the interrupt forever. Counter loads are made in the same cycle as a loop step, which shows whether a decrement overwrites the load. Fetches are made with valid low and with stall high, and a design that lets the pipeline or address move in those cycles is caught. Wrap-around at 0xFFF and a loop with a zero count are also covered.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    OP_NEXT  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CJMP  = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_LOOP  = 3'd5,
    OP_END   = 3'd6,
    OP_HWAIT = 3'd7
  } useq_op_e;

  // opcode map: nibble swap then scramble constant
  function automatic logic [7:0] opmap(input logic [7:0] op);
    return {op[3:0], op[7:4]} ^ 8'hA5;
  endfunction
endpackage

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-9:0] MAP_BASE = '0,
  parameter logic [AW-1:0] HOLD_VEC = '0,
  parameter logic [AW-1:0] IRQ_VEC  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  useq_op_e      op,
  input  logic [AW-1:0] upc,
  input  logic [AW-1:0] jump,
  input  logic [AW-1:0] save,
  input  logic          test_t,
  input  logic          cnt_zero,
  input  logic          hold_n,
  input  logic          irq_n,
  input  logic          skip,
  input  logic [7:0]    opcode,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] inc,
  output logic          do_call,
  output logic          cnt_dec,
  output logic          skip_set,
  output logic          skip_clr
);
  always_comb begin
    inc      = upc + 1'b1;
    nxt      = inc;
    do_call  = 1'b0;
    cnt_dec  = 1'b0;
    skip_set = 1'b0;
    skip_clr = 1'b0;
    unique case (op)
      OP_NEXT: nxt = inc;
      OP_JUMP: nxt = jump;
      OP_CJMP: nxt = test_t ? jump : inc;
      OP_CALL: begin nxt = jump; do_call = 1'b1; end
      OP_RET:  nxt = save;
      OP_LOOP: begin
        if (!cnt_zero) begin
          nxt     = jump;
          cnt_dec = 1'b1;
        end
      end
      OP_END: begin
        if (!hold_n)               nxt = HOLD_VEC;
        else if (!irq_n && !skip)  nxt = IRQ_VEC;
        else begin
          nxt      = {MAP_BASE, opmap(opcode)};
          skip_clr = 1'b1;
        end
      end
      OP_HWAIT: begin
        if (!hold_n) nxt = upc;
        else         skip_set = 1'b1;
      end
      default: nxt = inc;
    endcase
  end

  // R10
  hold_first_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_END && !hold_n) |-> (nxt == HOLD_VEC));
  // R11
  skip_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(skip_set && skip_clr));
endmodule

// File: rtl/useq_loopcnt.sv
module useq_loopcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          ld,
  input  logic          ld_bus,
  input  logic [CW-1:0] bus_val,
  input  logic [CW-1:0] field_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (adv && ld)     cnt_q <= ld_bus ? bus_val : field_val;
    else if (adv && dec)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R6
  loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && dec && !ld) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7
  load_src_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && ld && ld_bus) |=> (cnt_q == $past(bus_val)));
  // R12
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q));
endmodule

// File: rtl/useq_ipipe.sv
module useq_ipipe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] slot_b
);
  logic [DW-1:0] slot_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_a <= '0;
      slot_b <= '0;
    end else if (xfer) begin
      slot_a <= din;
      slot_b <= slot_a;
    end
  end

  // R8
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (slot_b == $past(slot_a) && slot_a == $past(din)));
  // R8
  pipe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> ($stable(slot_a) && $stable(slot_b)));
endmodule

// File: rtl/useq_addr_gen.sv
module useq_addr_gen
  import useq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-9:0] MAP_BASE = 4'h2,
  parameter logic [AW-1:0] HOLD_VEC = 12'h0F0,
  parameter logic [AW-1:0] IRQ_VEC  = 12'h0E0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic [2:0]    mw_op,
  input  logic [AW-1:0] mw_jump,
  input  logic          mw_fetch,
  input  logic          mw_cnt_ld,
  input  logic          mw_cnt_bus,
  input  logic [DW-1:0] mw_cnt_val,
  input  logic          test_t,
  input  logic          hold_n,
  input  logic          irq_n,
  input  logic [DW-1:0] data_bus,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [DW-1:0] instr_data,
  output logic [AW-1:0] uaddr,
  output logic          cnt_done,
  output logic [DW-1:0] cur_instr
);
  localparam int OPW = 8;

  useq_op_e      op;
  logic [AW-1:0] upc_q, save_q, nxt, inc;
  logic          skip_q, adv, xfer;
  logic          do_call, cnt_dec, skip_set, skip_clr;

  assign op          = useq_op_e'(mw_op);
  assign instr_ready = mw_fetch && !stall && !rst;
  assign adv         = !stall && !(mw_fetch && !instr_valid);
  assign xfer        = instr_ready && instr_valid;

  useq_next #(.AW(AW), .MAP_BASE(MAP_BASE), .HOLD_VEC(HOLD_VEC), .IRQ_VEC(IRQ_VEC)) u_next (
    .clk(clk), .rst(rst), .op(op), .upc(upc_q), .jump(mw_jump), .save(save_q),
    .test_t(test_t), .cnt_zero(cnt_done), .hold_n(hold_n), .irq_n(irq_n),
    .skip(skip_q), .opcode(cur_instr[DW-1 -: OPW]), .nxt(nxt), .inc(inc),
    .do_call(do_call), .cnt_dec(cnt_dec), .skip_set(skip_set), .skip_clr(skip_clr)
  );

  useq_loopcnt #(.CW(DW)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .ld(mw_cnt_ld), .ld_bus(mw_cnt_bus),
    .bus_val(data_bus), .field_val(mw_cnt_val), .dec(cnt_dec), .zero(cnt_done)
  );

  useq_ipipe #(.DW(DW)) u_pipe (
    .clk(clk), .rst(rst), .xfer(xfer), .din(instr_data), .slot_b(cur_instr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q  <= '0;
      save_q <= '0;
      skip_q <= 1'b0;
    end else if (adv) begin
      upc_q <= nxt;
      if (do_call)  save_q <= inc;
      if (skip_set) skip_q <= 1'b1;
      else if (skip_clr) skip_q <= 1'b0;
    end
  end

  assign uaddr = upc_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (upc_q == '0));
  // R12
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(upc_q) && $stable(save_q) && $stable(skip_q)));
  // R5
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && op == OP_CALL) |=> (save_q == $past(upc_q) + 1'b1 && upc_q == $past(mw_jump)));
  // R8
  ready_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !instr_ready);
endmodule

// File: tb/sim_useq_addr_gen.sv
module sim_useq_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] HV = 12'h0F0, IV = 12'h0E0;
  localparam logic [3:0]  MB = 4'h2;

  logic clk = 0, rst = 1, stall = 0;
  logic [2:0] mw_op = 0;
  logic [11:0] mw_jump = 0;
  logic mw_fetch = 0, mw_cnt_ld = 0, mw_cnt_bus = 0;
  logic [15:0] mw_cnt_val = 0, data_bus = 0, instr_data = 0;
  logic test_t = 0, hold_n = 1, irq_n = 1, instr_valid = 0;
  logic instr_ready, cnt_done;
  logic [11:0] uaddr;
  logic [15:0] cur_instr;

  int checks = 0, errors = 0;
  logic [11:0] m_upc = 0, m_save = 0;
  logic [15:0] m_cnt = 0, m_ia = 0, m_ib = 0;
  logic m_skip = 0;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_addr_gen u0 (.*);

  function automatic logic [7:0] emap(input logic [7:0] o);
    return {o[3:0], o[7:4]} ^ 8'hA5;
  endfunction

  task automatic chk(input logic ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // one machine cycle: inputs already driven after a negedge
  task automatic cycle();
    logic adv, rdy;
    logic [11:0] inc, nx;
    logic [15:0] ncnt;
    logic dec;
    #1;
    rdy = mw_fetch && !stall && !rst;
    chk(instr_ready == rdy, "R8 ready", instr_ready, rdy);
    adv = !stall && !(mw_fetch && !instr_valid);
    inc = m_upc + 12'd1;
    nx = inc; dec = 0; tag = "R2";
    if (rst) begin
      tag = "R1"; m_upc = 0; m_save = 0; m_cnt = 0; m_ia = 0; m_ib = 0; m_skip = 0;
    end else if (!adv) begin
      tag = stall ? "R12" : "R8";
    end else begin
      case (mw_op)
        3'd1: begin nx = mw_jump; tag = "R3"; end
        3'd2: begin nx = test_t ? mw_jump : inc; tag = "R4"; end
        3'd3: begin nx = mw_jump; m_save = inc; tag = "R5"; end
        3'd4: begin nx = m_save; tag = "R5"; end
        3'd5: begin tag = "R6"; if (m_cnt != 0) begin nx = mw_jump; dec = 1; end end
        3'd6: begin
          if (!hold_n) begin nx = HV; tag = "R10"; end
          else if (!irq_n && !m_skip) begin nx = IV; tag = "R10"; end
          else begin
            nx = {MB, emap(m_ib[15:8])};
            tag = (!irq_n) ? "R11" : "R9";
            m_skip = 0;
          end
        end
        3'd7: begin tag = "R11"; if (!hold_n) nx = m_upc; else m_skip = 1; end
        default: ;
      endcase
      ncnt = m_cnt;
      if (mw_cnt_ld) ncnt = mw_cnt_bus ? data_bus : mw_cnt_val;
      else if (dec) ncnt = m_cnt - 16'd1;
      m_cnt = ncnt;
      if (mw_fetch && instr_valid) begin m_ib = m_ia; m_ia = instr_data; end
      m_upc = nx;
    end
    @(posedge clk); #2;
    chk(uaddr == m_upc, tag, uaddr, m_upc);
    chk(cnt_done == (m_cnt == 0), mw_cnt_ld ? "R7" : "R6", cnt_done, m_cnt == 0);
    chk(cur_instr == m_ib, "R8", cur_instr, m_ib);
    @(negedge clk);
  endtask

  task automatic mw(input int op, input logic [11:0] j);
    mw_op = op[2:0]; mw_jump = j; mw_fetch = 0; mw_cnt_ld = 0; stall = 0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1750));
    @(negedge clk);
    // R1 reset
    mw(1, 12'h123); cycle(); cycle();
    rst = 0;
    mw(0, 0); cycle();
    chk(uaddr == 12'd1, "R1 start", uaddr, 1);
    // fill pipeline, R8
    mw(0, 0); mw_fetch = 1; instr_valid = 1; instr_data = 16'h3C00; cycle();
    instr_data = 16'h7100; cycle();
    instr_valid = 0; cycle(); cycle(); // waiting on valid
    instr_valid = 1; stall = 1; cycle(); // R12 with fetch
    stall = 0; mw_fetch = 0;
    // R2 wrap
    mw(1, 12'hFFF); cycle(); mw(0, 0); cycle();
    // R5 call/return
    mw(3, 12'h400); cycle(); mw(0, 0); cycle(); mw(4, 0); cycle();
    // R4
    mw(2, 12'h050); test_t = 0; cycle(); test_t = 1; cycle();
    // R7 load field then loop R6; load beats loop
    mw(5, 12'h200); mw_cnt_ld = 1; mw_cnt_val = 16'd2; cycle();
    mw(5, 12'h200); cycle(); cycle(); cycle(); cycle();
    mw(5, 12'h210); mw_cnt_ld = 1; mw_cnt_bus = 1; data_bus = 16'd1; cycle();
    mw_cnt_bus = 0; mw(5, 12'h210); cycle(); cycle();
    // R10: hold and irq together, hold wins
    mw(6, 0); hold_n = 0; irq_n = 0; cycle();
    mw(7, 0); cycle(); cycle();          // R11 wait
    hold_n = 1; cycle();                 // leave hold, arm skip
    mw(6, 0); cycle();                   // R11 dispatch despite irq
    mw(6, 0); cycle();                   // R10 irq now taken
    irq_n = 1; mw(6, 0); cycle();        // R9 plain dispatch
    // R12 stall on a jump
    mw(1, 12'h777); stall = 1; cycle(); cycle(); stall = 0; cycle();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      mw_op       = 3'($urandom_range(0, 7));
      mw_jump     = 12'($urandom);
      mw_fetch    = ($urandom_range(0, 9) < 3);
      instr_valid = ($urandom_range(0, 9) < 7);
      instr_data  = 16'($urandom);
      mw_cnt_ld   = ($urandom_range(0, 9) < 2);
      mw_cnt_bus  = $urandom_range(0, 1) == 1;
      mw_cnt_val  = 16'($urandom_range(0, 4));
      data_bus    = 16'($urandom_range(0, 4));
      test_t      = $urandom_range(0, 1) == 1;
      hold_n      = ($urandom_range(0, 9) >= 2);
      irq_n       = ($urandom_range(0, 9) >= 3);
      stall       = ($urandom_range(0, 9) == 0);
      rst         = ($urandom_range(0, 299) == 0);
      cycle();
    end
    rst = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule